// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a cache and main memory. Stores, and dirty lines pushed out by a refill, are taken into a small queue. The queue drains to memory in arrival order whenever the memory port is not needed by a read. Each queue entry holds one address and one data word. A store to an address that is already queued overwrites that entry instead of taking a new slot.

A read miss does not have to wait behind the queued writes. The block compares the miss address with every queued entry. If no entry matches, the memory read is issued next, ahead of all pending writes. If an entry matches, one of three policies applies, chosen by parameters. With forwarding, the queued data answers the read directly. Without forwarding, the read is held until the matching entry has been written. The conservative policy waits for the whole queue to empty before the read is issued.

A refill that evicts a dirty line presents the victim store and the read miss in the same cycle. The victim is queued, the read goes out first, and the requester is released when the read data returns, while the victim is still queued.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the queue is empty, `st_ready` and `ld_ready` are 1, and `mem_req` and `ld_done` are 0.
- R2: Accepted stores are written to memory (`mem_we`=1) in acceptance order, one per granted cycle, when no read holds the port.
- R3: With DEPTH entries queued, `st_ready` is 0 and a store offered then is not taken.
- R4: A store whose address matches a queued entry that is not leaving in that cycle replaces that entry's data without using a new slot, so memory sees one write carrying the latest data.
- R5: A read whose address matches no entry is issued as a memory read (`mem_we`=0) in the first granted cycle after acceptance, before any queued write.
- R6: With FWD_EN=1 and WAIT_EMPTY=0, a read that matches an entry gets that entry's data on `ld_data`, with `ld_done` high two cycles after acceptance and no memory access.
- R7: With FWD_EN=0, a read that matches an entry is held until that entry has been written, and is then read from memory.
- R8: With WAIT_EMPTY=1, a read is issued only after every queued write has been written.
- R9: A store and a read accepted in the same cycle: the store is queued, and the read reaches memory before it and before older queued writes.
- R10: `ld_done` rises in the cycle after `mem_rvalid`, carrying `mem_rdata`, even while writes remain queued.
- R11: While a read is waiting to be issued or forwarded, `st_ready` is 0.
- R12: `ld_ready` is 0 from the acceptance of a read until the cycle in which `ld_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Read miss offered |
| ld_ready | output | 1 | Read miss can be taken |
| ld_addr | input | AW | Read miss address |
| ld_done | output | 1 | One-cycle pulse: read data valid |
| ld_data | output | DW | Read result |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory takes the request this cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
Reads are tried against a queue holding no matching address, a matching address, and a freshly merged address. These cases separate bypass from forwarding, and show whether forwarded data is the newest. A store and a read presented in the same cycle show whether the victim is queued behind the read. The hold and drain-first variants get the same matching and non-matching loads, so the order of memory events tells the three policies apart. The write sequences, which fill the queue, overflow it and repeat addresses, separate ordering, stalling and merging in the memory trace.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {RD_IDLE = 2'd0, RD_PEND = 2'd1, RD_WAIT = 2'd2} rd_state_e;

  // read may go to memory now
  function automatic logic may_issue(input logic drain_first, input logic buf_empty,
                                     input logic hit);
    return drain_first ? buf_empty : !hit;
  endfunction

  // read may be answered from the queue
  function automatic logic may_forward(input logic fwd_en, input logic drain_first,
                                       input logic hit);
    return fwd_en && !drain_first && hit;
  endfunction
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  input  logic [AW-1:0]                lk_addr,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH):0]       cnt,
  output logic [AW-1:0]                head_addr,
  output logic [DW-1:0]                head_data,
  output logic                         lk_hit,
  output logic [DW-1:0]                lk_data,
  output logic                         merge
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] a_q [DEPTH];
  logic [DW-1:0] d_q [DEPTH];
  logic [PW-1:0] head_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] m_idx, l_idx, tail;
  logic          m_any, append;

  // oldest to youngest: the last match found is the youngest
  always_comb begin
    m_any  = 1'b0;
    m_idx  = head_q;
    lk_hit = 1'b0;
    l_idx  = head_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt_q) begin
        if (a_q[head_q + PW'(i)] == push_addr) begin
          m_any = 1'b1;
          m_idx = head_q + PW'(i);
        end
        if (a_q[head_q + PW'(i)] == lk_addr) begin
          lk_hit = 1'b1;
          l_idx  = head_q + PW'(i);
        end
      end
    end
  end

  assign merge     = push && m_any && !(pop && (m_idx == head_q));
  assign append    = push && !merge;
  assign tail      = head_q + cnt_q[PW-1:0];
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign cnt       = cnt_q;
  assign head_addr = a_q[head_q];
  assign head_data = d_q[head_q];
  assign lk_data   = d_q[l_idx];

  always_ff @(posedge clk) begin
    if (merge) d_q[m_idx] <= push_data;
    if (append) begin
      a_q[tail] <= push_addr;
      d_q[tail] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) head_q <= head_q + PW'(1);
      if (append && !pop)      cnt_q <= cnt_q + CW'(1);
      else if (!append && pop) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/wbuf_rdctl.sv
module wbuf_rdctl
  import wbuf_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter bit FWD_EN     = 1'b1,
  parameter bit WAIT_EMPTY = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic          buf_empty,
  input  logic          lk_hit,
  input  logic [DW-1:0] lk_data,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          ld_ready,
  output logic          ld_done,
  output logic [DW-1:0] ld_data,
  output logic [AW-1:0] rd_addr,
  output logic          rd_req,
  output logic          rd_pend,
  output logic          rd_wait
);
  rd_state_e st_q;
  logic      fwd_now;

  assign ld_ready = (st_q == RD_IDLE);
  assign rd_pend  = (st_q == RD_PEND);
  assign rd_wait  = (st_q == RD_WAIT);
  assign fwd_now  = rd_pend && may_forward(FWD_EN, WAIT_EMPTY, lk_hit);
  assign rd_req   = rd_pend && !fwd_now && may_issue(WAIT_EMPTY, buf_empty, lk_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= RD_IDLE;
      ld_done <= 1'b0;
      ld_data <= '0;
      rd_addr <= '0;
    end else begin
      ld_done <= 1'b0;
      case (st_q)
        RD_IDLE: if (ld_valid) begin
          rd_addr <= ld_addr;
          st_q    <= RD_PEND;
        end
        RD_PEND: begin
          if (fwd_now) begin
            ld_done <= 1'b1;
            ld_data <= lk_data;
            st_q    <= RD_IDLE;
          end else if (rd_req && mem_gnt) begin
            st_q <= RD_WAIT;
          end
        end
        RD_WAIT: if (mem_rvalid) begin
          ld_done <= 1'b1;
          ld_data <= mem_rdata;
          st_q    <= RD_IDLE;
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
  import wbuf_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int DEPTH      = 4,
  parameter bit FWD_EN     = 1'b1,
  parameter bit WAIT_EMPTY = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_done,
  output logic [DW-1:0] ld_data,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          buf_full, buf_empty, lk_hit, st_push, st_merge;
  logic          wr_issue, wr_pop, rd_req, rd_pend, rd_wait;
  logic [AW-1:0] head_addr, rd_addr;
  logic [DW-1:0] head_data, lk_data;
  logic [CW-1:0] buf_cnt;

  assign st_ready  = !buf_full && !rd_pend;
  assign st_push   = st_valid && st_ready;
  assign wr_issue  = !rd_req && !rd_wait && !buf_empty;
  assign wr_pop    = wr_issue && mem_gnt;
  assign mem_req   = rd_req || wr_issue;
  assign mem_we    = wr_issue;
  assign mem_addr  = rd_req ? rd_addr : head_addr;
  assign mem_wdata = head_data;

  wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n),
    .push(st_push), .push_addr(st_addr), .push_data(st_data),
    .pop(wr_pop), .lk_addr(rd_addr),
    .full(buf_full), .empty(buf_empty), .cnt(buf_cnt),
    .head_addr(head_addr), .head_data(head_data),
    .lk_hit(lk_hit), .lk_data(lk_data), .merge(st_merge)
  );

  wbuf_rdctl #(.AW(AW), .DW(DW), .FWD_EN(FWD_EN), .WAIT_EMPTY(WAIT_EMPTY)) rdctl_i (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_addr(ld_addr),
    .buf_empty(buf_empty), .lk_hit(lk_hit), .lk_data(lk_data),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_ready(ld_ready), .ld_done(ld_done), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_req(rd_req), .rd_pend(rd_pend), .rd_wait(rd_wait)
  );
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          ld_ready,
  input logic          ld_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_rvalid,
  input logic          buf_full,
  input logic          st_merge,
  input logic          wr_pop,
  input logic          rd_pend,
  input logic          rd_wait,
  input logic [CW-1:0] buf_cnt
);
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !st_ready); // R3
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !st_merge && !wr_pop) |=> (buf_cnt == $past(buf_cnt) + CW'(1))); // R2
  AST_MERGE_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_merge && !wr_pop) |=> $stable(buf_cnt)); // R4
  AST_READ_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wait |-> !(mem_req && mem_we)); // R5
  AST_RELEASE_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wait && mem_rvalid) |=> ld_done); // R10
  AST_PEND_STALLS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !st_ready); // R11
  AST_PEND_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend || rd_wait) |-> !ld_ready); // R12
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .ld_ready(ld_ready), .ld_done(ld_done), .mem_req(mem_req), .mem_we(mem_we),
  .mem_rvalid(mem_rvalid), .buf_full(buf_full), .st_merge(st_merge),
  .wr_pop(wr_pop), .rd_pend(rd_pend), .rd_wait(rd_wait), .buf_cnt(buf_cnt)
);

// File: tb/wbuf_bypass_tb_top.sv
module wbuf_mem_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gnt_en,
  input  logic        req,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [31:0] wdata,
  output logic        gnt,
  output logic        rvalid,
  output logic [31:0] rdata
);
  logic [31:0] mem [256];
  logic        lg_we [256];
  logic [15:0] lg_addr [256];
  logic [31:0] lg_data [256];
  int          n_ev;

  assign gnt = gnt_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      n_ev   <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 32'hC0DE0000 + i;
    end else begin
      rvalid <= 1'b0;
      if (req && gnt) begin
        lg_we[n_ev]   <= we;
        lg_addr[n_ev] <= addr;
        lg_data[n_ev] <= we ? wdata : mem[addr[7:0]];
        n_ev          <= n_ev + 1;
        if (we) mem[addr[7:0]] <= wdata;
        else begin
          rvalid <= 1'b1;
          rdata  <= mem[addr[7:0]];
        end
      end
    end
  end
endmodule

module wbuf_bypass_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5ns clk = ~clk;

  logic        st_valid [3];
  logic        st_ready [3];
  logic [15:0] st_addr  [3];
  logic [31:0] st_data  [3];
  logic        ld_valid [3];
  logic        ld_ready [3];
  logic [15:0] ld_addr  [3];
  logic        ld_done  [3];
  logic [31:0] ld_data  [3];
  logic        mem_req  [3];
  logic        mem_gnt  [3];
  logic        mem_we   [3];
  logic [15:0] mem_addr [3];
  logic [31:0] mem_wdata[3];
  logic        mem_rvalid[3];
  logic [31:0] mem_rdata[3];
  logic        gnt_en   [3];

  int checks = 0;
  int errors = 0;

  wbuf_bypass #(.FWD_EN(1'b1), .WAIT_EMPTY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid[0]), .st_ready(st_ready[0]),
    .st_addr(st_addr[0]), .st_data(st_data[0]), .ld_valid(ld_valid[0]),
    .ld_ready(ld_ready[0]), .ld_addr(ld_addr[0]), .ld_done(ld_done[0]),
    .ld_data(ld_data[0]), .mem_req(mem_req[0]), .mem_gnt(mem_gnt[0]),
    .mem_we(mem_we[0]), .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]),
    .mem_rvalid(mem_rvalid[0]), .mem_rdata(mem_rdata[0]));
  wbuf_bypass #(.FWD_EN(1'b0), .WAIT_EMPTY(1'b0)) dut_hold (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid[1]), .st_ready(st_ready[1]),
    .st_addr(st_addr[1]), .st_data(st_data[1]), .ld_valid(ld_valid[1]),
    .ld_ready(ld_ready[1]), .ld_addr(ld_addr[1]), .ld_done(ld_done[1]),
    .ld_data(ld_data[1]), .mem_req(mem_req[1]), .mem_gnt(mem_gnt[1]),
    .mem_we(mem_we[1]), .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]),
    .mem_rvalid(mem_rvalid[1]), .mem_rdata(mem_rdata[1]));
  wbuf_bypass #(.FWD_EN(1'b1), .WAIT_EMPTY(1'b1)) dut_drain (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid[2]), .st_ready(st_ready[2]),
    .st_addr(st_addr[2]), .st_data(st_data[2]), .ld_valid(ld_valid[2]),
    .ld_ready(ld_ready[2]), .ld_addr(ld_addr[2]), .ld_done(ld_done[2]),
    .ld_data(ld_data[2]), .mem_req(mem_req[2]), .mem_gnt(mem_gnt[2]),
    .mem_we(mem_we[2]), .mem_addr(mem_addr[2]), .mem_wdata(mem_wdata[2]),
    .mem_rvalid(mem_rvalid[2]), .mem_rdata(mem_rdata[2]));

  wbuf_mem_model m0 (.clk(clk), .rst_n(rst_n), .gnt_en(gnt_en[0]), .req(mem_req[0]),
    .we(mem_we[0]), .addr(mem_addr[0]), .wdata(mem_wdata[0]), .gnt(mem_gnt[0]),
    .rvalid(mem_rvalid[0]), .rdata(mem_rdata[0]));
  wbuf_mem_model m1 (.clk(clk), .rst_n(rst_n), .gnt_en(gnt_en[1]), .req(mem_req[1]),
    .we(mem_we[1]), .addr(mem_addr[1]), .wdata(mem_wdata[1]), .gnt(mem_gnt[1]),
    .rvalid(mem_rvalid[1]), .rdata(mem_rdata[1]));
  wbuf_mem_model m2 (.clk(clk), .rst_n(rst_n), .gnt_en(gnt_en[2]), .req(mem_req[2]),
    .we(mem_we[2]), .addr(mem_addr[2]), .wdata(mem_wdata[2]), .gnt(mem_gnt[2]),
    .rvalid(mem_rvalid[2]), .rdata(mem_rdata[2]));

  function automatic void chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  function automatic int n_ev(input int k);
    case (k)
      0:       return m0.n_ev;
      1:       return m1.n_ev;
      default: return m2.n_ev;
    endcase
  endfunction

  // packs {we, addr, data-low-12} of memory event idx for comparison
  function automatic logic [31:0] ev(input int k, input int idx);
    logic        w;
    logic [15:0] a;
    logic [31:0] d;
    case (k)
      0:       begin w = m0.lg_we[idx]; a = m0.lg_addr[idx]; d = m0.lg_data[idx]; end
      1:       begin w = m1.lg_we[idx]; a = m1.lg_addr[idx]; d = m1.lg_data[idx]; end
      default: begin w = m2.lg_we[idx]; a = m2.lg_addr[idx]; d = m2.lg_data[idx]; end
    endcase
    return {3'b0, w, a[7:0], 8'h0, d[11:0]};
  endfunction

  function automatic logic [31:0] evx(input logic w, input logic [7:0] a, input logic [11:0] d);
    return {3'b0, w, a, 8'h0, d};
  endfunction

  task automatic do_store(input int k, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    st_valid[k] = 1'b1; st_addr[k] = a; st_data[k] = d;
    while (!st_ready[k]) @(negedge clk);
    @(negedge clk);
    st_valid[k] = 1'b0;
  endtask

  task automatic do_load(input int k, input logic [15:0] a, output logic [31:0] d, output int lat);
    @(negedge clk);
    ld_valid[k] = 1'b1; ld_addr[k] = a;
    while (!ld_ready[k]) @(negedge clk);
    @(negedge clk);
    ld_valid[k] = 1'b0;
    lat = 1;
    while (!ld_done[k] && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    d = ld_data[k];
  endtask

  task automatic drain(input int k);
    gnt_en[k] = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 st_ready", {31'b0, st_ready[0]}, 32'd1);
    chk("R1 ld_ready", {31'b0, ld_ready[0]}, 32'd1);
    chk("R1 mem_req",  {31'b0, mem_req[0]}, 32'd0);
    chk("R1 ld_done",  {31'b0, ld_done[0]}, 32'd0);
  endtask

  task automatic t_order;
    int b;
    gnt_en[0] = 1'b0; b = n_ev(0);
    do_store(0, 16'h10, 32'hA1);
    do_store(0, 16'h11, 32'hA2);
    do_store(0, 16'h12, 32'hA3);
    chk("R2 no write without grant", n_ev(0), b);
    drain(0);
    chk("R2 write count", n_ev(0), b + 3);
    chk("R2 first write",  ev(0, b),     evx(1'b1, 8'h10, 12'hA1));
    chk("R2 second write", ev(0, b + 1), evx(1'b1, 8'h11, 12'hA2));
    chk("R2 third write",  ev(0, b + 2), evx(1'b1, 8'h12, 12'hA3));
  endtask

  task automatic t_full;
    int b;
    gnt_en[0] = 1'b0; b = n_ev(0);
    for (int i = 0; i < 4; i++) do_store(0, 16'h20 + 16'(i), 32'hB0 + i);
    chk("R3 st_ready low when full", {31'b0, st_ready[0]}, 32'd0);
    st_valid[0] = 1'b1; st_addr[0] = 16'h2F; st_data[0] = 32'hBAD;
    repeat (3) @(negedge clk);
    st_valid[0] = 1'b0;
    drain(0);
    chk("R3 only queued writes reach memory", n_ev(0), b + 4);
    chk("R3 last write is fourth entry", ev(0, b + 3), evx(1'b1, 8'h23, 12'h0B3));
  endtask

  task automatic t_merge;
    int b;
    gnt_en[0] = 1'b0; b = n_ev(0);
    do_store(0, 16'h30, 32'h1);
    do_store(0, 16'h31, 32'h2);
    do_store(0, 16'h30, 32'h3);
    chk("R4 room left after merge", {31'b0, st_ready[0]}, 32'd1);
    drain(0);
    chk("R4 merged write count", n_ev(0), b + 2);
    chk("R4 merged entry keeps slot, latest data", ev(0, b), evx(1'b1, 8'h30, 12'h3));
    chk("R4 other entry", ev(0, b + 1), evx(1'b1, 8'h31, 12'h2));
  endtask

  task automatic t_fwd;
    int b, lat;
    logic [31:0] d;
    gnt_en[0] = 1'b0; b = n_ev(0);
    do_store(0, 16'h40, 32'h5);
    do_store(0, 16'h40, 32'h7);
    do_store(0, 16'h41, 32'h9);
    do_load(0, 16'h40, d, lat);
    chk("R6 forwarded data is newest", d, 32'h7);
    chk("R6 forward latency", lat, 2);
    chk("R6 no memory access", n_ev(0), b);
    drain(0);
  endtask

  task automatic t_bypass;
    int b, lat, nw;
    logic [31:0] d;
    gnt_en[0] = 1'b0; b = n_ev(0);
    do_store(0, 16'h50, 32'h1);
    do_store(0, 16'h51, 32'h2);
    fork
      do_load(0, 16'h58, d, lat);
      begin @(negedge clk); @(negedge clk); gnt_en[0] = 1'b1; end
    join
    nw = n_ev(0);
    chk("R5 read data from memory", d, 32'hC0DE0058);
    chk("R10 released on data return", lat, 3);
    chk("R10 writes still queued at release", nw, b + 1);
    chk("R5 read goes first", ev(0, b), evx(1'b0, 8'h58, 12'h058));
    drain(0);
    chk("R5 writes follow", ev(0, b + 1), evx(1'b1, 8'h50, 12'h1));
    chk("R5 writes follow in order", ev(0, b + 2), evx(1'b1, 8'h51, 12'h2));
  endtask

  task automatic t_victim;
    int b, lat, nw;
    gnt_en[0] = 1'b0; b = n_ev(0);
    do_store(0, 16'h60, 32'h4);
    @(negedge clk);
    st_valid[0] = 1'b1; st_addr[0] = 16'h61; st_data[0] = 32'h5;
    ld_valid[0] = 1'b1; ld_addr[0] = 16'h68;
    @(negedge clk);
    st_valid[0] = 1'b0; ld_valid[0] = 1'b0; gnt_en[0] = 1'b1;
    lat = 1;
    while (!ld_done[0] && lat < 200) begin @(negedge clk); lat++; end
    nw = n_ev(0);
    chk("R9 read data", ld_data[0], 32'hC0DE0068);
    chk("R9 victim not yet written at release", nw, b + 1);
    drain(0);
    chk("R9 read first", ev(0, b), evx(1'b0, 8'h68, 12'h068));
    chk("R9 older write next", ev(0, b + 1), evx(1'b1, 8'h60, 12'h4));
    chk("R9 victim write last", ev(0, b + 2), evx(1'b1, 8'h61, 12'h5));
  endtask

  task automatic t_hold;
    int b, lat;
    logic [31:0] d;
    gnt_en[1] = 1'b0; b = n_ev(1);
    do_store(1, 16'h70, 32'h6);
    do_store(1, 16'h71, 32'h8);
    fork
      do_load(1, 16'h71, d, lat);
      begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R11 store stalled while read pending", {31'b0, st_ready[1]}, 32'd0);
        chk("R12 no new read while pending", {31'b0, ld_ready[1]}, 32'd0);
        gnt_en[1] = 1'b1;
      end
    join
    chk("R7 data after entry written", d, 32'h8);
    chk("R7 first write", ev(1, b), evx(1'b1, 8'h70, 12'h6));
    chk("R7 matching write before read", ev(1, b + 1), evx(1'b1, 8'h71, 12'h8));
    chk("R7 read last", ev(1, b + 2), evx(1'b0, 8'h71, 12'h8));
  endtask

  task automatic t_drain_first;
    int b, lat;
    logic [31:0] d;
    gnt_en[2] = 1'b0; b = n_ev(2);
    do_store(2, 16'h80, 32'h1);
    do_store(2, 16'h81, 32'h2);
    fork
      do_load(2, 16'h88, d, lat);
      begin @(negedge clk); @(negedge clk); gnt_en[2] = 1'b1; end
    join
    chk("R8 read data", d, 32'hC0DE0088);
    chk("R8 first write before read", ev(2, b), evx(1'b1, 8'h80, 12'h1));
    chk("R8 second write before read", ev(2, b + 1), evx(1'b1, 8'h81, 12'h2));
    chk("R8 read after empty", ev(2, b + 2), evx(1'b0, 8'h88, 12'h088));
  endtask

  initial begin
    #1ms;
    checks++; errors++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      st_valid[k] = 1'b0; st_addr[k] = '0; st_data[k] = '0;
      ld_valid[k] = 1'b0; ld_addr[k] = '0; gnt_en[k] = 1'b1;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_merge();
    t_fwd();
    t_bypass();
    t_victim();
    t_hold();
    t_drain_first();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule